// File: doc/BRIEF.md
# Integer-N Feedback Divider with Fixed Reference Divider

This block produces the two comparison ticks for a phase-locked synthesizer loop. On the feedback side it divides a fast oscillator clock by a programmed integer N. It does this with a 32/33 dual-modulus prescaler, a swallow counter and a slower program counter. Software supplies only N and a channel code. The hardware splits N into a program count M = N div 32 and a swallow count S = N mod 32. It then divides by 33 for S prescaler periods and by 32 for the remaining M − S periods, so the total is 32·M + S = N oscillator cycles.

On the reference side, a separate fixed divider counts reference-clock cycles and emits one tick every 65 of them. With a 13 MHz reference this gives a 200 kHz comparison rate, and the synthesized frequency is N times that rate.

Each load is checked against rules that depend on the channel code. A rejected word raises a one-cycle error flag and leaves the running divide ratio untouched. An accepted word is held until the feedback cycle in progress ends, so a count is never cut short.

Top module: `nDivTop`

## Requirements
- R1: While `rstN` is low and after reset, `fbPulse`, `refPulse` and `loadErr` are low. `fbPulse` stays low until a valid N has been accepted.
- R2: Once running, `fbPulse` is high for exactly one `vcoClk` cycle in every N `vcoClk` cycles.
- R3: The feedback count is built from M = N div 32 prescaler periods, of which the first S = N mod 32 last 33 cycles and the rest last 32. This must hold at the edge cases S = 0 (N = 64) and S = M (N = 99, N = 1023).
- R4: `refPulse` is high for one `refClk` cycle in every 65 `refClk` cycles.
- R5: An N accepted while a feedback cycle is running leaves that cycle's length at the old N. The next cycle uses the new N.
- R6: `chanSel` codes are 0 for RF1 (all 18 bits usable), 1 for RF2 (bit 17 must be 0) and 2 for IF (bits 17:16 must be 0). Code 3 rejects every load.
- R7: On the IF channel only N = 7150, 7215 or 7280 is accepted. Any other value is rejected.
- R8: An N below 64, or one with S > M, is rejected on every channel.
- R9: `loadErr` is high for one `vcoClk` cycle, one cycle after a `loadStb` that carries a rejected word. It stays low after an accepted word, and a rejected word does not change the feedback period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vcoClk | input | 1 | Fast oscillator-side clock being divided |
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| nIn | input | 18 | Requested divide ratio N |
| chanSel | input | 2 | Channel code applied to the load (0 RF1, 1 RF2, 2 IF, 3 reserved) |
| loadStb | input | 1 | One-cycle load strobe in the `vcoClk` domain |
| fbPulse | output | 1 | Feedback tick, once per N `vcoClk` cycles |
| refPulse | output | 1 | Reference tick, once per 65 `refClk` cycles |
| loadErr | output | 1 | One-cycle flag for a rejected load |

## Verification
The divider is driven with ratios whose swallow part is zero, equal to the program count, or at its maximum of 31. This separates a wrong modulus choice from an off-by-one in either counter, because each of these faults gives a period that differs from N in a different way. Rejected words are spread across all three rules: too small, S > M, and width or value set for the channel. After each one the old period is measured again, which shows that the rejection did not leak into the running ratio. A load placed in the middle of a long IF cycle, followed by a short RF ratio, shows whether the change waits for the cycle boundary. The reference tick is timed separately in its own clock domain.

// File: rtl/nDivPkg.sv
package nDivPkg;

  typedef enum logic [1:0] {
    CH_RF1 = 2'd0,
    CH_RF2 = 2'd1,
    CH_IF  = 2'd2,
    CH_RSV = 2'd3
  } chanCode_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic haveN;   // a valid ratio is held and may be (re)loaded
  } divCmd_t;

endpackage

// File: rtl/nDivCtrl.sv
module nDivCtrl
  import nDivPkg::*;
#(
  parameter int NW       = 18,
  parameter int RF2_W    = 17,
  parameter int IF_W     = 16,
  parameter int PRE_LOG2 = 5,
  parameter int MIN_N    = 64,
  parameter int IF_N0    = 7150,
  parameter int IF_N1    = 7215,
  parameter int IF_N2    = 7280,
  localparam int MW      = NW - PRE_LOG2
) (
  input  logic                vcoClk,
  input  logic                rstN,
  input  logic [NW-1:0]       nIn,
  input  logic [1:0]          chanSel,
  input  logic                loadStb,
  output divCmd_t             divCmd,
  output logic [NW-1:0]       nActive,
  output logic [MW-1:0]       splitM,
  output logic [PRE_LOG2-1:0] splitS,
  output logic                loadErr
);

  localparam int NIF = 3;
  localparam logic [NW-1:0] IF_LIST [NIF] = '{NW'(IF_N0), NW'(IF_N1), NW'(IF_N2)};

  chanCode_e           chan;
  logic [MW-1:0]       inM;
  logic [PRE_LOG2-1:0] inS;
  logic                widthOk;
  logic                ifHit;
  logic                minOk;
  logic                splitOk;
  logic                wordOk;
  logic                haveN;

  assign chan = chanCode_e'(chanSel);
  assign inM  = nIn[NW-1:PRE_LOG2];
  assign inS  = nIn[PRE_LOG2-1:0];

  always_comb begin
    ifHit = 1'b0;
    for (int i = 0; i < NIF; i++) begin
      if (nIn == IF_LIST[i]) ifHit = 1'b1;
    end
  end

  always_comb begin
    unique case (chan)
      CH_RF1:  widthOk = 1'b1;
      CH_RF2:  widthOk = (nIn[NW-1:RF2_W] == '0);
      CH_IF:   widthOk = (nIn[NW-1:IF_W] == '0) && ifHit;
      default: widthOk = 1'b0;
    endcase
  end

  assign minOk   = (nIn >= NW'(MIN_N));
  assign splitOk = ({{(MW-PRE_LOG2){1'b0}}, inS} <= inM);
  assign wordOk  = widthOk && minOk && splitOk;

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      nActive <= '0;
      haveN   <= 1'b0;
      loadErr <= 1'b0;
    end else begin
      loadErr <= 1'b0;
      if (loadStb) begin
        if (wordOk) begin
          nActive <= nIn;
          haveN   <= 1'b1;
        end else begin
          loadErr <= 1'b1;
        end
      end
    end
  end

  assign divCmd.haveN = haveN;
  assign splitM       = nActive[NW-1:PRE_LOG2];
  assign splitS       = nActive[PRE_LOG2-1:0];

endmodule

// File: rtl/nDivPath.sv
module nDivPath
  import nDivPkg::*;
#(
  parameter int NW       = 18,
  parameter int PRE_LOG2 = 5,
  localparam int MW      = NW - PRE_LOG2,
  localparam int PCW     = PRE_LOG2 + 1,
  localparam int PRE_P   = 1 << PRE_LOG2
) (
  input  logic                vcoClk,
  input  logic                rstN,
  input  divCmd_t             divCmd,
  input  logic [MW-1:0]       splitM,
  input  logic [PRE_LOG2-1:0] splitS,
  output logic                fbPulse
);

  logic                running;
  logic [PCW-1:0]      preCnt;
  logic [MW-1:0]       mLeft;
  logic [PRE_LOG2-1:0] sLeft;
  logic                inSwallow;
  logic                periodEnd;

  // swallow periods count one extra cycle (modulus P+1)
  assign inSwallow = (sLeft != '0);
  assign periodEnd = inSwallow ? (preCnt == PCW'(PRE_P)) : (preCnt == PCW'(PRE_P - 1));

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
      mLeft   <= '0;
      sLeft   <= '0;
      fbPulse <= 1'b0;
    end else begin
      fbPulse <= 1'b0;
      if (!running) begin
        if (divCmd.haveN) begin
          running <= 1'b1;
          preCnt  <= '0;
          mLeft   <= splitM - MW'(1);
          sLeft   <= splitS;
        end
      end else if (periodEnd) begin
        preCnt <= '0;
        if (mLeft == '0) begin
          fbPulse <= 1'b1;
          mLeft   <= splitM - MW'(1);
          sLeft   <= splitS;
        end else begin
          mLeft <= mLeft - MW'(1);
          if (inSwallow) sLeft <= sLeft - PRE_LOG2'(1);
        end
      end else begin
        preCnt <= preCnt + PCW'(1);
      end
    end
  end

endmodule

// File: rtl/refDiv.sv
module refDiv #(
  parameter int REF_DIV = 65,
  localparam int RW     = $clog2(REF_DIV)
) (
  input  logic refClk,
  input  logic rstN,
  output logic refPulse
);

  logic [RW-1:0] refCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refCnt   <= '0;
      refPulse <= 1'b0;
    end else begin
      refPulse <= (refCnt == RW'(REF_DIV - 1));
      refCnt   <= (refCnt == RW'(REF_DIV - 1)) ? '0 : refCnt + RW'(1);
    end
  end

endmodule

// File: rtl/nDivTop.sv
module nDivTop
  import nDivPkg::*;
#(
  parameter int NW       = 18,
  parameter int RF2_W    = 17,
  parameter int IF_W     = 16,
  parameter int PRE_LOG2 = 5,
  parameter int MIN_N    = 64,
  parameter int REF_DIV  = 65,
  parameter int IF_N0    = 7150,
  parameter int IF_N1    = 7215,
  parameter int IF_N2    = 7280,
  localparam int MW      = NW - PRE_LOG2
) (
  input  logic          vcoClk,
  input  logic          refClk,
  input  logic          rstN,
  input  logic [NW-1:0] nIn,
  input  logic [1:0]    chanSel,
  input  logic          loadStb,
  output logic          fbPulse,
  output logic          refPulse,
  output logic          loadErr
);

  divCmd_t             divCmd;
  logic [NW-1:0]       nActive;
  logic [MW-1:0]       splitM;
  logic [PRE_LOG2-1:0] splitS;

  nDivCtrl #(
    .NW(NW), .RF2_W(RF2_W), .IF_W(IF_W), .PRE_LOG2(PRE_LOG2), .MIN_N(MIN_N),
    .IF_N0(IF_N0), .IF_N1(IF_N1), .IF_N2(IF_N2)
  ) uCtrl (
    .vcoClk(vcoClk), .rstN(rstN), .nIn(nIn), .chanSel(chanSel), .loadStb(loadStb),
    .divCmd(divCmd), .nActive(nActive), .splitM(splitM), .splitS(splitS),
    .loadErr(loadErr)
  );

  nDivPath #(.NW(NW), .PRE_LOG2(PRE_LOG2)) uPath (
    .vcoClk(vcoClk), .rstN(rstN), .divCmd(divCmd), .splitM(splitM),
    .splitS(splitS), .fbPulse(fbPulse)
  );

  refDiv #(.REF_DIV(REF_DIV)) uRef (
    .refClk(refClk), .rstN(rstN), .refPulse(refPulse)
  );

endmodule

// File: rtl/nDivChecker.sv
module nDivChecker #(
  parameter int NW       = 18,
  parameter int PRE_LOG2 = 5,
  localparam int MW      = NW - PRE_LOG2
) (
  input logic                vcoClk,
  input logic                refClk,
  input logic                rstN,
  input logic                loadStb,
  input logic                fbPulse,
  input logic                refPulse,
  input logic                loadErr,
  input logic                haveN,
  input logic [NW-1:0]       nActive,
  input logic [MW-1:0]       splitM,
  input logic [PRE_LOG2-1:0] splitS
);

  // R1: no feedback tick before a valid ratio is held
  a_r1_idle_quiet: assert property (@(posedge vcoClk) disable iff (!rstN)
    !haveN |-> !fbPulse);

  // R2: feedback tick lasts one cycle
  a_r2_single_fb: assert property (@(posedge vcoClk) disable iff (!rstN)
    fbPulse |=> !fbPulse);

  // R3: held ratio always has a legal swallow split
  a_r3_split_legal: assert property (@(posedge vcoClk) disable iff (!rstN)
    haveN |-> ({{(MW-PRE_LOG2){1'b0}}, splitS} <= splitM));

  // R4: reference tick lasts one cycle
  a_r4_single_ref: assert property (@(posedge refClk) disable iff (!rstN)
    refPulse |=> !refPulse);

  // R8: a rejected word leaves the held ratio unchanged
  a_r8_keep_ratio: assert property (@(posedge vcoClk) disable iff (!rstN)
    loadErr |-> $stable(nActive));

  // R9: an error flag only follows a load strobe
  a_r9_err_after_load: assert property (@(posedge vcoClk) disable iff (!rstN)
    loadErr |-> $past(loadStb));

endmodule

bind nDivTop nDivChecker #(.NW(NW), .PRE_LOG2(PRE_LOG2)) uChk (
  .vcoClk(vcoClk), .refClk(refClk), .rstN(rstN), .loadStb(loadStb),
  .fbPulse(fbPulse), .refPulse(refPulse), .loadErr(loadErr),
  .haveN(divCmd.haveN), .nActive(nActive), .splitM(splitM), .splitS(splitS)
);

// File: tb/nDivTop_test.sv
`timescale 1ns/1ps
module nDivTop_test;

  logic        vcoClk = 1'b0;
  logic        refClk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] nIn = '0;
  logic [1:0]  chanSel = '0;
  logic        loadStb = 1'b0;
  logic        fbPulse, refPulse, loadErr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int lastN = 0;

  always #4 vcoClk = ~vcoClk;   // 125 MHz
  always #5 refClk = ~refClk;

  nDivTop uut (
    .vcoClk(vcoClk), .refClk(refClk), .rstN(rstN), .nIn(nIn), .chanSel(chanSel),
    .loadStb(loadStb), .fbPulse(fbPulse), .refPulse(refPulse), .loadErr(loadErr)
  );

  // vector: {chan[1:0], ok, n[17:0]}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 1'b1, 18'd64},            // R3 S=0, R8 minimum
    {2'd0, 1'b0, 18'd63},            // R8 below minimum
    {2'd0, 1'b0, 18'd100},           // R8 S>M (M=3,S=4)
    {2'd0, 1'b1, 18'd99},            // R3 S=M
    {2'd0, 1'b1, 18'd1023},          // R3 S=31=M
    {2'd0, 1'b1, 18'd1000},          // R2
    {2'd1, 1'b0, 18'd131172},        // R6 RF2 bit17 set
    {2'd1, 1'b1, 18'd2047},          // R6 RF2 legal
    {2'd3, 1'b0, 18'd500},           // R6 reserved code
    {2'd2, 1'b1, 18'd7150},          // R7
    {2'd2, 1'b0, 18'd7000},          // R7 not in list
    {2'd2, 1'b0, 18'd2047},          // R7 legal elsewhere, not IF
    {2'd2, 1'b1, 18'd7215},          // R7
    {2'd1, 1'b1, 18'd7280},          // R6 RF2 accepts it too
    {2'd2, 1'b1, 18'd7280}           // R7
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadN(input logic [1:0] ch, input logic [17:0] n, output bit err);
    @(negedge vcoClk);
    chanSel = ch; nIn = n; loadStb = 1'b1;
    @(negedge vcoClk);
    loadStb = 1'b0;
    err = loadErr;
  endtask

  task automatic waitPulse();
    do @(negedge vcoClk); while (!fbPulse);
  endtask

  // counts vcoClk cycles to the next fbPulse; loads a word at cycle 'at'
  task automatic period(input int at, input logic [1:0] ch, input logic [17:0] n,
                        output int cnt);
    cnt = 0;
    do begin
      @(negedge vcoClk);
      cnt++;
      if (cnt == at) begin chanSel = ch; nIn = n; loadStb = 1'b1; end
      else loadStb = 1'b0;
    end while (!fbPulse);
    loadStb = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge vcoClk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit err;
    int cnt;
    int seen;

    // R1: reset state
    repeat (3) @(negedge vcoClk);
    check(!fbPulse && !refPulse && !loadErr, "R1 reset outputs", fbPulse + refPulse + loadErr, 0);
    rstN = 1'b1;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge vcoClk);
      if (fbPulse || loadErr) seen++;
    end
    check(seen == 0, "R1 idle before valid N", seen, 0);

    // R4: reference tick spacing
    do @(negedge refClk); while (!refPulse);
    for (int k = 0; k < 2; k++) begin
      cnt = 0;
      do begin @(negedge refClk); cnt++; end while (!refPulse);
      check(cnt == 65, "R4 reference period", cnt, 65);
    end

    // Vector table: R2 R3 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  ch;
      logic        ok;
      logic [17:0] n;
      {ch, ok, n} = VEC[v];
      loadN(ch, n, err);
      check(err == !ok, $sformatf("R9 loadErr vec%0d", v), int'(err), int'(!ok));
      @(negedge vcoClk);
      check(!loadErr, $sformatf("R9 loadErr one cycle vec%0d", v), int'(loadErr), 0);
      if (ok) lastN = int'(n);
      waitPulse();
      period(0, 2'd0, 18'd0, cnt);
      check(cnt == lastN, $sformatf("R2 R3 R8 period vec%0d", v), cnt, lastN);
    end

    // R5: load mid-cycle; the running cycle keeps the old ratio
    waitPulse();
    period(10, 2'd0, 18'd640, cnt);
    check(cnt == 7280, "R5 running cycle keeps old N", cnt, 7280);
    period(0, 2'd0, 18'd0, cnt);
    check(cnt == 640, "R5 next cycle uses new N", cnt, 640);
    period(0, 2'd0, 18'd0, cnt);
    check(cnt == 640, "R2 steady period", cnt, 640);

    // R9 R8: rejected word mid-cycle does not disturb the period
    period(20, 2'd0, 18'd40, cnt);
    check(cnt == 640, "R9 rejected load keeps period", cnt, 640);
    period(0, 2'd0, 18'd0, cnt);
    check(cnt == 640, "R8 period after rejected load", cnt, 640);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule